// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits in a receive path and decides whether a frame is kept, judging only by its 48-bit destination address. Software loads a table of sixteen exact addresses by streaming a setup image through a byte port. Each frame's destination address then arrives as six bytes in wire order, along with the frame length. A fixed number of cycles later, the block returns one decision with a done pulse.

Four mode inputs change the decision. Promiscuous and receive-all accept everything and raise a filtering-failed flag. Pass-all-multicast accepts any group address and raises a multicast flag. Inverse mode turns the perfect-match result upside down. The broadcast address always passes, and runt frames are always dropped.

Top module: `dest_addr_filter`

## Requirements
- R1: The table has 16 entries of 6 bytes. After reset every entry is zero, so with all modes clear the all-zero address is accepted.
- R2: A setup stream ends with the byte that carries `cfg_last`. The table is replaced only when that stream has exactly 192 bytes. A stream of any other length leaves every entry as it was.
- R3: Table entry n comes from setup offsets 12n+0, +1, +4, +5, +8 and +9, which become address bytes 0 to 5. Byte 0 is the first byte on the wire. The other six bytes of each 12-byte slot have no effect.
- R4: The address FF:FF:FF:FF:FF:FF is accepted with both flags low. This holds in every mode combination, including inverse mode.
- R5: When R4 does not apply and `mode_prom` or `mode_rxall` is set, the frame is accepted with `dec_ffail`=1 and `dec_mcast`=0.
- R6: When R4 and R5 do not apply, `mode_mcast` is set, and bit 0 of address byte 0 is 1, the frame is accepted with `dec_mcast`=1.
- R7: In every other case, the result is a match against any of the 16 entries, XORed with `mode_inv`. Both flags are low.
- R8: A frame whose `da_len` (sampled with `da_first`) is below 14 is rejected with both flags low. This rule takes priority over all the others.
- R9: Call edge k the clock edge that samples the sixth address byte. `dec_done` is high for exactly one cycle, in the cycle after edge k+1. The decision uses the modes and the table as they stand just before edge k+1. While `dec_done` is low, `dec_accept`, `dec_ffail` and `dec_mcast` are 0.
- R10: `da_first` restarts address collection at byte 0, dropping any partial address. Address bytes can follow each other with no idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Setup byte valid |
| cfg_data | input | 8 | Setup byte |
| cfg_last | input | 1 | Marks the final byte of a setup stream |
| da_valid | input | 1 | Address byte valid |
| da_first | input | 1 | Marks address byte 0 |
| da_data | input | 8 | Address byte, wire order |
| da_len | input | LEN_W | Frame length in bytes, sampled with `da_first` |
| mode_prom | input | 1 | Promiscuous mode |
| mode_rxall | input | 1 | Receive-all mode |
| mode_mcast | input | 1 | Pass-all-multicast mode |
| mode_inv | input | 1 | Inverse perfect filtering |
| dec_done | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_ffail | output | 1 | Accepted by promiscuous or receive-all |
| dec_mcast | output | 1 | Accepted by pass-all-multicast |

## Verification
The assertions assume that `cfg_last` and `da_first` are only ever high together with their own valid strobe. They also assume that every address begins with `da_first`, so that its length is sampled. The timing rules assume the modes do not change between the sixth byte and the decision edge. The stimulus changes modes only while the address port is idle, starts every address with `da_first`, and drives all inputs at the falling edge. It also includes restarted addresses, back-to-back addresses, setup streams of 191, 192 and 193 bytes, and a lookup built from the ignored setup bytes.

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int NENT    = 16,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [7:0]       cfg_data,
  input  logic             cfg_last,
  input  logic             da_valid,
  input  logic             da_first,
  input  logic [7:0]       da_data,
  input  logic [LEN_W-1:0] da_len,
  input  logic             mode_prom,
  input  logic             mode_rxall,
  input  logic             mode_mcast,
  input  logic             mode_inv,
  output logic             dec_done,
  output logic             dec_accept,
  output logic             dec_ffail,
  output logic             dec_mcast
);
  localparam int SLOT_BYTES = 12;
  localparam int SETUP_LEN  = NENT * SLOT_BYTES;
  localparam int CNT_W      = $clog2(SETUP_LEN + 2);
  localparam int ENT_W      = (NENT > 1) ? $clog2(NENT) : 1;

  // setup stream: staged into a shadow table, committed on an exact-length end
  logic [CNT_W-1:0]          cfg_cnt;
  logic [3:0]                cfg_off;
  logic [ENT_W-1:0]          cfg_ent;
  logic [NENT-1:0][5:0][7:0] shadow, shadow_nxt, table_q;
  logic [2:0]                cfg_slot;
  logic                      cfg_keep, cfg_commit;

  assign cfg_slot   = {cfg_off[3:2], 1'b0} + {2'b00, cfg_off[0]};
  assign cfg_keep   = cfg_valid && !cfg_off[1] && (cfg_cnt < CNT_W'(SETUP_LEN));
  assign cfg_commit = cfg_valid && cfg_last && (cfg_cnt == CNT_W'(SETUP_LEN - 1));

  always_comb begin
    shadow_nxt = shadow;
    if (cfg_keep) shadow_nxt[cfg_ent][cfg_slot] = cfg_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_cnt <= '0;
      cfg_off <= '0;
      cfg_ent <= '0;
      shadow  <= '0;
      table_q <= '0;
    end else if (cfg_valid) begin
      shadow <= shadow_nxt;
      if (cfg_commit) table_q <= shadow_nxt;
      if (cfg_last) begin
        cfg_cnt <= '0;
        cfg_off <= '0;
        cfg_ent <= '0;
      end else begin
        if (cfg_cnt != CNT_W'(SETUP_LEN + 1)) cfg_cnt <= cfg_cnt + CNT_W'(1);
        if (cfg_off == 4'd11) begin
          cfg_off <= '0;
          cfg_ent <= cfg_ent + ENT_W'(1);
        end else begin
          cfg_off <= cfg_off + 4'd1;
        end
      end
    end
  end

  // address collection
  logic [2:0]      da_idx, eff_idx;
  logic [4:0][7:0] da_hold;
  logic            short_hold, short_q, cand_q;
  logic [5:0][7:0] addr_q;

  assign eff_idx = da_first ? 3'd0 : da_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da_idx     <= '0;
      da_hold    <= '0;
      short_hold <= 1'b0;
      short_q    <= 1'b0;
      cand_q     <= 1'b0;
      addr_q     <= '0;
    end else begin
      cand_q <= 1'b0;
      if (da_valid) begin
        if (da_first) short_hold <= (da_len < LEN_W'(MIN_LEN));
        if (eff_idx == 3'd5) begin
          addr_q  <= {da_data, da_hold};
          short_q <= short_hold;
          cand_q  <= 1'b1;
          da_idx  <= '0;
        end else begin
          da_hold[eff_idx] <= da_data;
          da_idx           <= eff_idx + 3'd1;
        end
      end
    end
  end

  // parallel compare against every entry
  logic [NENT-1:0] hit;
  for (genvar i = 0; i < NENT; i++) begin : g_cmp
    assign hit[i] = (table_q[i] == addr_q);
  end

  logic is_bc, is_mc, acc_c, ff_c, mf_c;
  assign is_bc = &addr_q;
  assign is_mc = addr_q[0][0];

  always_comb begin
    acc_c = 1'b0;
    ff_c  = 1'b0;
    mf_c  = 1'b0;
    if (short_q) begin
      acc_c = 1'b0;
    end else if (is_bc) begin
      acc_c = 1'b1;
    end else if (mode_prom || mode_rxall) begin
      acc_c = 1'b1;
      ff_c  = 1'b1;
    end else if (mode_mcast && is_mc) begin
      acc_c = 1'b1;
      mf_c  = 1'b1;
    end else begin
      acc_c = (|hit) ^ mode_inv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_done   <= 1'b0;
      dec_accept <= 1'b0;
      dec_ffail  <= 1'b0;
      dec_mcast  <= 1'b0;
    end else begin
      dec_done   <= cand_q;
      dec_accept <= cand_q && acc_c;
      dec_ffail  <= cand_q && ff_c;
      dec_mcast  <= cand_q && mf_c;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) dec_done |=> !dec_done); // R9
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) cand_q |=> dec_done); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !dec_done |-> !dec_accept && !dec_ffail && !dec_mcast); // R9
  AST_FLAG_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (dec_ffail || dec_mcast) |-> dec_accept); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dec_ffail && dec_mcast)); // R6
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n) cand_q && short_q |=> !dec_accept && !dec_ffail && !dec_mcast); // R8
  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n) cand_q && !short_q && (&addr_q) |=> dec_accept && !dec_ffail && !dec_mcast); // R4
  AST_PROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cand_q && !short_q && !(&addr_q) && (mode_prom || mode_rxall) |=> dec_ffail); // R5
  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_valid && cfg_last) |=> $stable(table_q)); // R2
endmodule

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0, cfg_last = 0, da_valid = 0, da_first = 0;
  logic [7:0] cfg_data = 0, da_data = 0;
  logic [10:0] da_len = 0;
  logic mode_prom = 0, mode_rxall = 0, mode_mcast = 0, mode_inv = 0;
  logic dec_done, dec_accept, dec_ffail, dec_mcast;

  always #(CLK_PERIOD/2) clk = ~clk;

  dest_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_last(cfg_last),
    .da_valid(da_valid), .da_first(da_first), .da_data(da_data), .da_len(da_len),
    .mode_prom(mode_prom), .mode_rxall(mode_rxall), .mode_mcast(mode_mcast), .mode_inv(mode_inv),
    .dec_done(dec_done), .dec_accept(dec_accept), .dec_ffail(dec_ffail), .dec_mcast(dec_mcast));

  int total = 0, bad = 0;
  bit finished = 0;
  string scen = "R9 reset";

  // behavioural reference model
  logic [7:0] m_tab [16][6];
  logic [7:0] m_buf [256];
  logic [7:0] m_abuf [6];
  logic [7:0] m_addr [6];
  int m_cnt, m_idx;
  bit m_short, m_pshort, m_pend;
  bit e_done, e_acc, e_ff, e_mf;
  string e_tag = "R9 idle";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_tab[n, b]) m_tab[n][b] = 8'h00;
      m_cnt = 0; m_idx = 0; m_short = 0; m_pend = 0;
      e_done = 0; e_acc = 0; e_ff = 0; e_mf = 0; e_tag = "R9 idle";
    end else begin
      e_done = 0; e_acc = 0; e_ff = 0; e_mf = 0; e_tag = "R9 idle";
      if (m_pend) begin
        bit bc, hitany;
        bc = 1; hitany = 0;
        for (int b = 0; b < 6; b++) if (m_addr[b] != 8'hFF) bc = 0;
        for (int n = 0; n < 16; n++) begin
          bit eq;
          eq = 1;
          for (int b = 0; b < 6; b++) if (m_tab[n][b] != m_addr[b]) eq = 0;
          if (eq) hitany = 1;
        end
        e_done = 1;
        if (m_pshort) begin e_tag = "R8 runt"; end
        else if (bc) begin e_acc = 1; e_tag = "R4 broadcast"; end
        else if (mode_prom || mode_rxall) begin e_acc = 1; e_ff = 1; e_tag = "R5 promiscuous"; end
        else if (mode_mcast && m_addr[0][0]) begin e_acc = 1; e_mf = 1; e_tag = "R6 multicast"; end
        else begin e_acc = hitany ^ mode_inv; e_tag = "R1 R3 R7 perfect match"; end
        m_pend = 0;
      end
      if (cfg_valid) begin
        if (m_cnt < 256) m_buf[m_cnt] = cfg_data;
        m_cnt++;
        if (cfg_last) begin
          if (m_cnt == 192)
            for (int n = 0; n < 16; n++)
              for (int b = 0; b < 6; b++) m_tab[n][b] = m_buf[12*n + (b/2)*4 + (b%2)];
          m_cnt = 0;
        end
      end
      if (da_valid) begin
        if (da_first) begin m_idx = 0; m_short = (da_len < 14); end
        m_abuf[m_idx] = da_data;
        m_idx++;
        if (m_idx == 6) begin
          m_addr = m_abuf; m_pshort = m_short; m_pend = 1; m_idx = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (dec_done !== e_done || dec_accept !== e_acc || dec_ffail !== e_ff || dec_mcast !== e_mf) begin
        bad++;
        $display("FAIL %s [%s]: got done=%0d acc=%0d ff=%0d mf=%0d expected done=%0d acc=%0d ff=%0d mf=%0d",
                 e_tag, scen, dec_done, dec_accept, dec_ffail, dec_mcast, e_done, e_acc, e_ff, e_mf);
      end
    end
  end

  function automatic logic [7:0] img(int i, int seed);
    int n, off, b;
    n = i / 12; off = i % 12;
    if (off % 4 < 2) begin
      b = (off / 4) * 2 + off % 2;
      return (b == 0) ? 8'(seed + 2*n) : 8'(16*b + n + seed);
    end
    return 8'(8'hA5 ^ i);
  endfunction

  function automatic logic [47:0] entry(int n, int seed);
    logic [47:0] a;
    for (int b = 0; b < 6; b++) a[8*b +: 8] = img(12*n + (b/2)*4 + (b%2), seed);
    return a;
  endfunction

  task automatic idle(int n);
    cfg_valid = 0; cfg_last = 0; da_valid = 0; da_first = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_setup(int len, int seed);
    for (int i = 0; i < len; i++) begin
      cfg_valid = 1; cfg_data = img(i, seed); cfg_last = (i == len - 1);
      @(negedge clk);
    end
    idle(2);
  endtask

  task automatic lookup(logic [47:0] a, int len, int gap);
    for (int b = 0; b < 6; b++) begin
      da_valid = 1; da_first = (b == 0); da_data = a[8*b +: 8]; da_len = 11'(len);
      @(negedge clk);
    end
    idle(gap);
  endtask

  task automatic set_modes(bit p, bit r, bit m, bit v);
    mode_prom = p; mode_rxall = r; mode_mcast = m; mode_inv = v;
    @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MISS_U = 48'h0000_0000_3302;
  localparam logic [47:0] MISS_M = 48'h0000_0000_3301;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    if (dec_done !== 0 || dec_accept !== 0 || dec_ffail !== 0 || dec_mcast !== 0) begin
      bad++;
      $display("FAIL R9 reset outputs: got %b%b%b%b expected 0000", dec_done, dec_accept, dec_ffail, dec_mcast);
    end
    scen = "R1 zero table after reset";
    lookup(48'h0, 64, 3);
    lookup(MISS_U, 64, 3);

    scen = "R2 R3 full setup";
    send_setup(192, 8'h20);
    lookup(entry(0, 8'h20), 64, 3);
    lookup(entry(15, 8'h20), 64, 3);
    lookup(entry(7, 8'h20), 64, 3);
    lookup(48'h0, 64, 3);
    scen = "R3 ignored bytes";
    lookup({img(11, 8'h20), img(10, 8'h20), img(7, 8'h20), img(6, 8'h20), img(3, 8'h20), img(2, 8'h20)}, 64, 3);
    scen = "R4 broadcast";
    lookup(BCAST, 64, 3);

    scen = "R7 inverse";
    set_modes(0, 0, 0, 1);
    lookup(entry(3, 8'h20), 64, 3);
    lookup(MISS_U, 64, 3);
    scen = "R4 broadcast inverse";
    lookup(BCAST, 64, 3);

    scen = "R5 promiscuous";
    set_modes(1, 0, 0, 0);
    lookup(MISS_U, 64, 3);
    lookup(MISS_M, 64, 3);
    set_modes(0, 1, 0, 1);
    lookup(entry(2, 8'h20), 64, 3);
    scen = "R5 priority over multicast";
    set_modes(1, 0, 1, 0);
    lookup(MISS_M, 64, 3);

    scen = "R6 pass multicast";
    set_modes(0, 0, 1, 0);
    lookup(MISS_M, 64, 3);
    lookup(MISS_U, 64, 3);
    lookup(entry(4, 8'h20), 64, 3);
    set_modes(0, 0, 0, 0);
    scen = "R6 multicast off";
    lookup(MISS_M, 64, 3);

    scen = "R8 runt";
    lookup(BCAST, 13, 3);
    lookup(entry(1, 8'h20), 13, 3);
    set_modes(1, 0, 0, 0);
    lookup(MISS_U, 2, 3);
    set_modes(0, 0, 0, 0);
    lookup(entry(1, 8'h20), 14, 3);

    scen = "R2 short stream";
    send_setup(191, 8'h40);
    lookup(entry(5, 8'h20), 64, 3);
    lookup(entry(5, 8'h40), 64, 3);
    scen = "R2 long stream";
    send_setup(193, 8'h40);
    lookup(entry(6, 8'h20), 64, 3);
    lookup(entry(6, 8'h40), 64, 3);
    scen = "R2 reload";
    send_setup(192, 8'h40);
    lookup(entry(6, 8'h20), 64, 3);
    lookup(entry(6, 8'h40), 64, 3);

    scen = "R10 restart";
    for (int b = 0; b < 3; b++) begin
      da_valid = 1; da_first = (b == 0); da_data = 8'hFF; da_len = 64;
      @(negedge clk);
    end
    lookup(entry(9, 8'h40), 64, 3);
    scen = "R10 back to back";
    lookup(entry(10, 8'h40), 64, 0);
    lookup(BCAST, 64, 0);
    lookup(MISS_U, 64, 0);
    lookup(entry(11, 8'h40), 9, 4);

    summary();
  end
endmodule